// File: doc/BRIEF.md
# Bitstream Short-Circuit Detector

This block watches the raw one-bit stream of a sigma-delta modulator and flags a stuck input line. On every strobed bit it measures how long the current run of identical bits has lasted. When that run length reaches a programmable threshold, a short-circuit event is recorded. The run measurement can be restricted to runs of ones, runs of zeros, or runs of either value.

The detector runs only while the channel enable and the main enable are both high. A mode bit can narrow this further, so that detection works only while a filter conversion is in progress. While detection is gated off, the run measurement is held at zero. An event sets a sticky flag that a write-one-to-clear strobe removes. Under a separate enable, the event also raises a sticky break request that the same strobe clears.

Top module: `stuck_bit_detector`

## Requirements
- R1: With `run_opt` = 2'b00, runs of ones and runs of zeros are both measured, and an event is recorded on the strobed bit that makes the run length equal `run_limit`. `stuck_flag` is visible high right after the clock edge that samples that bit.
- R2: With `run_opt` = 2'b01, only runs of ones are measured. With `run_opt` = 2'b10, only runs of zeros are measured. A bit of the other value clears the run.
- R3: With `run_opt` = 2'b11, no event is ever recorded and the run measurement stays at zero.
- R4: `run_limit` is an 8-bit unsigned threshold, usable up to 255. A value of 0 never produces an event.
- R5: One run produces at most one event. The run count saturates at the limit, and a further event needs a new run after a bit of the other value.
- R6: With `gate_mode` = 0, detection is active exactly when `chan_en` and `main_en` are both high.
- R7: With `gate_mode` = 1, detection additionally requires `filt_busy` to be high.
- R8: While detection is inactive, the run count is held at zero, so a run interrupted by gating restarts from one.
- R9: A cycle with `bit_valid` low has no effect on the run, whatever `bit_in` is.
- R10: `stuck_flag` is sticky and is cleared by a one on `flag_clr`. An event in the same cycle as the clear leaves the flag set.
- R11: When `brk_en` is high, an event also sets the sticky `brk_req`. It is cleared by `flag_clr` just like the flag. With `brk_en` low, events leave `brk_req` low.
- R12: After reset, `stuck_flag`, `brk_req` and the run count are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | Strobe marking a new modulator bit |
| bit_in | input | 1 | Modulator bitstream |
| run_opt | input | 2 | 00 both, 01 ones, 10 zeros, 11 off |
| run_limit | input | 8 | Run-length threshold |
| gate_mode | input | 1 | 0: enables only, 1: also needs filt_busy |
| chan_en | input | 1 | Channel enable |
| main_en | input | 1 | Main enable |
| filt_busy | input | 1 | Filter conversion in progress |
| brk_en | input | 1 | Allows events to raise brk_req |
| flag_clr | input | 1 | Write-one-to-clear strobe for flag and break |
| stuck_flag | output | 1 | Sticky short-circuit flag |
| brk_req | output | 1 | Sticky break request |

## Verification
Two things can land on the same clock edge: the event that sets the sticky flag, and the clear strobe that removes it. The bench brings a run to one bit short of the limit. It then drives the completing bit and `flag_clr` together, and expects the flag to read high afterwards. A separate clear on a quiet cycle must then bring it low. The same pairing is checked on `brk_req`, which must also survive a coincident clear when `brk_en` is high.

// File: rtl/stuck_bit_pkg.sv
package stuck_bit_pkg;

    typedef enum logic [1:0] {
        RUN_BOTH  = 2'b00,
        RUN_ONES  = 2'b01,
        RUN_ZEROS = 2'b10,
        RUN_OFF   = 2'b11
    } run_opt_e;

    typedef struct packed {
        logic flag;
        logic brk;
    } sticky_t;

endpackage

// File: rtl/stuck_bit_gate.sv
module stuck_bit_gate
    import stuck_bit_pkg::*;
(
    input  logic       bit_in,
    input  logic [1:0] run_opt,
    input  logic       gate_mode,
    input  logic       chan_en,
    input  logic       main_en,
    input  logic       filt_busy,
    output logic       active,
    output logic       counted
);
    logic opt_live;
    logic cond_ok;

    always_comb begin
        opt_live = (run_opt_e'(run_opt) != RUN_OFF);
        cond_ok  = gate_mode ? filt_busy : 1'b1;
        active   = chan_en && main_en && cond_ok && opt_live;
        unique case (run_opt_e'(run_opt))
            RUN_BOTH:  counted = 1'b1;
            RUN_ONES:  counted = bit_in;
            RUN_ZEROS: counted = !bit_in;
            default:   counted = 1'b0;
        endcase
    end
endmodule

// File: rtl/stuck_bit_run.sv
module stuck_bit_run #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             counted,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] run_cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev;
    } run_t;

    run_t cur_q, nxt_d;
    logic restart;

    always_comb begin
        nxt_d   = cur_q;
        hit     = 1'b0;
        restart = 1'b0;
        if (!active) begin
            nxt_d.cnt = '0;
        end else if (bit_valid) begin
            nxt_d.prev = bit_in;
            if (!counted) begin
                nxt_d.cnt = '0;
            end else if ((cur_q.cnt != '0) && (bit_in == cur_q.prev)) begin
                if (cur_q.cnt < limit) begin
                    nxt_d.cnt = cur_q.cnt + ONE;
                end
            end else begin
                nxt_d.cnt = ONE;
                restart   = 1'b1;
            end
            hit = counted && (nxt_d.cnt == limit) && (restart || (cur_q.cnt != limit));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign run_cnt = cur_q.cnt;
endmodule

// File: rtl/stuck_bit_flag.sv
module stuck_bit_flag
    import stuck_bit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic brk_en,
    input  logic clr,
    output logic flag,
    output logic brk
);
    sticky_t st_q, st_d;

    always_comb begin
        st_d.flag = hit || (st_q.flag && !clr);
        st_d.brk  = (hit && brk_en) || (st_q.brk && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign brk  = st_q.brk;
endmodule

// File: rtl/stuck_bit_detector.sv
module stuck_bit_detector #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic [1:0]       run_opt,
    input  logic [CNT_W-1:0] run_limit,
    input  logic             gate_mode,
    input  logic             chan_en,
    input  logic             main_en,
    input  logic             filt_busy,
    input  logic             brk_en,
    input  logic             flag_clr,
    output logic             stuck_flag,
    output logic             brk_req
);
    logic             active_w;
    logic             counted_w;
    logic             hit_w;
    logic [CNT_W-1:0] run_cnt_w;

    stuck_bit_gate u_gate (
        .bit_in    (bit_in),
        .run_opt   (run_opt),
        .gate_mode (gate_mode),
        .chan_en   (chan_en),
        .main_en   (main_en),
        .filt_busy (filt_busy),
        .active    (active_w),
        .counted   (counted_w)
    );

    stuck_bit_run #(.CNT_W(CNT_W)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active_w),
        .counted   (counted_w),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .limit     (run_limit),
        .run_cnt   (run_cnt_w),
        .hit       (hit_w)
    );

    stuck_bit_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit_w),
        .brk_en (brk_en),
        .clr    (flag_clr),
        .flag   (stuck_flag),
        .brk    (brk_req)
    );
endmodule

// File: rtl/stuck_bit_detector_chk.sv
module stuck_bit_detector_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic [1:0]       run_opt,
    input logic             flag_clr,
    input logic             stuck_flag,
    input logic             brk_req,
    input logic             active,
    input logic [CNT_W-1:0] run_cnt
);
    // R8
    gated_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (run_cnt == '0));

    // R3
    reserved_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_opt == 2'b11) |=> (run_cnt == '0));

    // R9
    idle_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && active) |=> $stable(run_cnt));

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_flag && !flag_clr) |=> stuck_flag);

    // R10
    rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stuck_flag && !(bit_valid && active)) |=> !stuck_flag);

    // R11
    break_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> stuck_flag);
endmodule

bind stuck_bit_detector stuck_bit_detector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .run_opt    (run_opt),
    .flag_clr   (flag_clr),
    .stuck_flag (stuck_flag),
    .brk_req    (brk_req),
    .active     (active_w),
    .run_cnt    (run_cnt_w)
);

// File: tb/stuck_bit_detector_test.sv
module stuck_bit_detector_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic [1:0] run_opt = 2'b00;
    logic [7:0] run_limit = 8'd3;
    logic       gate_mode = 1'b0;
    logic       chan_en = 1'b1;
    logic       main_en = 1'b1;
    logic       filt_busy = 1'b0;
    logic       brk_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       stuck_flag;
    logic       brk_req;

    int checks = 0;
    int errors = 0;

    stuck_bit_detector uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .run_opt    (run_opt),
        .run_limit  (run_limit),
        .gate_mode  (gate_mode),
        .chan_en    (chan_en),
        .main_en    (main_en),
        .filt_busy  (filt_busy),
        .brk_en     (brk_en),
        .flag_clr   (flag_clr),
        .stuck_flag (stuck_flag),
        .brk_req    (brk_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic push(input logic b);
        bit_in    = b;
        bit_valid = 1'b1;
        @(posedge clk);
        #1;
        bit_valid = 1'b0;
    endtask

    task automatic push_n(input logic b, input int n);
        for (int i = 0; i < n; i++) push(b);
    endtask

    task automatic clear();
        flag_clr = 1'b1;
        @(posedge clk);
        #1;
        flag_clr = 1'b0;
    endtask

    function automatic logic polarity_counted(input int opt, input logic b);
        return (opt == 0) || (opt == 1 && b) || (opt == 2 && !b);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check("R12 flag", stuck_flag, 1'b0);
        check("R12 brk", brk_req, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1 R2 R3 R4: sweep option, polarity, limit, run length
        for (int opt = 0; opt < 4; opt++) begin
            for (int b = 0; b < 2; b++) begin
                for (int lim = 0; lim < 5; lim++) begin
                    for (int len = 1; len < 6; len++) begin
                        logic exp;
                        run_opt   = 2'(opt);
                        run_limit = 8'(lim);
                        push(!b[0]);
                        clear();
                        push_n(b[0], len);
                        exp = (opt != 3) && polarity_counted(opt, b[0]) &&
                              (lim != 0) && (len >= lim);
                        if (opt == 3)
                            check("R3 reserved option", stuck_flag, exp);
                        else if (lim == 0)
                            check("R4 zero limit", stuck_flag, exp);
                        else if (opt == 0)
                            check("R1 both polarities", stuck_flag, exp);
                        else
                            check("R2 single polarity", stuck_flag, exp);
                        check("R11 no break when disabled", brk_req, 1'b0);
                    end
                end
            end
        end

        // R2: opposite bit inside a ones run restarts the run
        run_opt = 2'b01; run_limit = 8'd3;
        push(1'b0); clear();
        push_n(1'b1, 2); push(1'b0); push_n(1'b1, 2);
        check("R2 broken ones run", stuck_flag, 1'b0);
        push(1'b1);
        check("R2 ones run completes", stuck_flag, 1'b1);

        // R4 R5: full 8-bit limit, single event per run
        run_opt = 2'b01; run_limit = 8'd255;
        push(1'b0); clear();
        push_n(1'b1, 254);
        check("R4 one short of 255", stuck_flag, 1'b0);
        push(1'b1);
        check("R4 reaches 255", stuck_flag, 1'b1);
        clear();
        push_n(1'b1, 50);
        check("R5 no second event in run", stuck_flag, 1'b0);
        push(1'b0); push_n(1'b1, 255);
        check("R5 new run fires again", stuck_flag, 1'b1);

        // R5 with small limit
        run_opt = 2'b00; run_limit = 8'd2;
        push(1'b1); clear();
        push_n(1'b0, 2); clear(); push_n(1'b0, 6);
        check("R5 saturated run silent", stuck_flag, 1'b0);

        // R6: each enable low blocks detection
        run_limit = 8'd3; gate_mode = 1'b0;
        push(1'b1); clear();
        chan_en = 1'b0; push_n(1'b0, 5);
        check("R6 channel enable low", stuck_flag, 1'b0);
        chan_en = 1'b1; main_en = 1'b0; push_n(1'b0, 5);
        check("R6 main enable low", stuck_flag, 1'b0);
        main_en = 1'b1; push_n(1'b0, 3);
        check("R6 both enables high", stuck_flag, 1'b1);

        // R7: filter-active gating
        clear(); gate_mode = 1'b1; filt_busy = 1'b0;
        push(1'b1); push_n(1'b0, 5);
        check("R7 filter idle", stuck_flag, 1'b0);
        filt_busy = 1'b1; push_n(1'b0, 3);
        check("R7 filter busy", stuck_flag, 1'b1);
        gate_mode = 1'b0; filt_busy = 1'b0;

        // R8: gating mid-run clears the count
        clear(); push(1'b1);
        push_n(1'b0, 2);
        chan_en = 1'b0; push(1'b0); chan_en = 1'b1;
        push(1'b0);
        check("R8 run restarted after gate", stuck_flag, 1'b0);
        push_n(1'b0, 2);
        check("R8 restarted run completes", stuck_flag, 1'b1);

        // R9: bits without strobe are ignored
        clear(); push(1'b1);
        push_n(1'b0, 2);
        bit_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R9 unstrobed bits no event", stuck_flag, 1'b0);
        push(1'b0);
        check("R9 run unaffected", stuck_flag, 1'b1);

        // R10 R11: coincident event and clear
        brk_en = 1'b1; run_limit = 8'd2;
        push(1'b1); clear(); push(1'b0);
        bit_in = 1'b0; bit_valid = 1'b1; flag_clr = 1'b1;
        @(posedge clk);
        #1;
        bit_valid = 1'b0; flag_clr = 1'b0;
        check("R10 event beats clear", stuck_flag, 1'b1);
        check("R11 break beats clear", brk_req, 1'b1);
        @(posedge clk);
        #1;
        check("R10 flag sticky", stuck_flag, 1'b1);
        clear();
        check("R10 cleared", stuck_flag, 1'b0);
        check("R11 break cleared", brk_req, 1'b0);
        brk_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule